// File: doc/BRIEF.md
# Emulation Visibility Bus Multiplexer

This block drives a debug visibility port that shares one set of pins between two kinds of data. A bus clock is made from the system clock: one system clock of high phase, then one of low phase. In the high phase the pins carry the address of the access that holds the current bus cycle. In the low phase they carry three things: a 3-bit code for the access source, a 4-bit instruction-queue status, and a 16-bit read-data visibility word.

A request is taken as a single record. It holds the address, the size (byte or word), the direction, the source code, the queue status, the stretch count and the read data. The block takes the record at the start of a bus cycle. It then holds the access for 1 + stretch bus cycles. The source code is shown in the access's first cycle, and the queue status and read data follow one cycle later. A two-stage register pipeline carries these fields, so the second-cycle fields of one access share a low phase with the first-cycle fields of the next access.

Top module: `evb_mux`

## Requirements
- R1: `eclk` is high for one system clock and low for the next, alternating, and the first phase after reset is high. In a high phase, `pad_acc` and `pad_iq` are 0.
- R2: In the high phase of a bus cycle, `pad_ad` carries the address of the access that holds that cycle. It carries 0 when the cycle is idle.
- R3: `req_v` is sampled only at the start of a bus cycle, and only when no access is still running. An accepted access holds 1 + `req_str` bus cycles.
- R4: In the low phase, `pad_acc` carries `req_src` in the first cycle of an access and 000 in each later cycle of that access. In an idle cycle it carries 100.
- R5: The queue status `req_iq` of an access appears on `pad_iq` in the low phase of the bus cycle after the access's first cycle. It reads 0000 from the access's third cycle until one cycle after the access ends, and 0000 in cycles that follow an idle cycle.
- R6: A word read at an even address shows the read data on `pad_ad` in the low phase, in the same cycle as the queue status. `req_data[15:8]` is the byte at the address and goes on bits 15:8. `req_data[7:0]` is the byte at address+1 and goes on bits 7:0.
- R7: A word read at an odd address puts the byte at address+1 (`req_data[7:0]`) on bits 15:8 and the byte at the address (`req_data[15:8]`) on bits 7:0.
- R8: A byte read uses `req_data[7:0]` as its data. At an even address the data goes on bits 15:8 and address bits 7:0 go on bits 7:0. At an odd address address bits 15:8 go on bits 15:8 and the data goes on bits 7:0.
- R9: The low-phase `pad_ad` is 0 in the following cases: writes, reads whose source is not a CPU source (the CPU sources are 001 and 010 only), and cycles in which no queue status is shown.
- R10: When accesses follow back to back, the next access's source code shares a low phase with the previous access's queue status or its 0000 null status.
- R11: A request made while an access is still running has no effect on any output.
- R12: While reset is held, `eclk`, `pad_ad`, `pad_acc` and `pad_iq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, two per bus cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_v | input | 1 | Request present at the start of a bus cycle |
| req_addr | input | 16 | Access address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_src | input | 3 | Access-source code (000 not used) |
| req_iq | input | 4 | Instruction-queue status for this access |
| req_str | input | 4 | Extra bus cycles to stretch the access |
| req_data | input | 16 | Read data for the access |
| eclk | output | 1 | Bus clock, high phase first |
| pad_ad | output | 16 | Address in high phase, read-data visibility in low phase |
| pad_acc | output | 3 | Access-source code in low phase |
| pad_iq | output | 4 | Queue status in low phase |

## Verification
A request presented before the clock edge that starts bus cycle c shows its address in the system clock that follows that edge. Its source code appears one system clock later, in the low phase of cycle c. Its queue status and read data appear two system clocks after that, in the low phase of cycle c+1. The bench drives each request before the edge that starts a cycle. It samples at the falling edge in the middle of each phase and compares every phase of every bus cycle with values written out by hand. This makes every lag count, including the null cycles and the shared low phases of back-to-back accesses.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int AW    = 16;
  localparam int DW    = 16;
  localparam int SRC_W = 3;
  localparam int IQ_W  = 4;

  localparam logic [SRC_W-1:0] SRC_NONE    = 3'b000;
  localparam logic [SRC_W-1:0] SRC_CPU_PRG = 3'b001;
  localparam logic [SRC_W-1:0] SRC_CPU_DAT = 3'b010;
  localparam logic [SRC_W-1:0] SRC_IDLE    = 3'b100;

  typedef struct packed {
    logic [AW-1:0]    addr;
    logic             word;
    logic             rd;
    logic [SRC_W-1:0] src;
    logic [IQ_W-1:0]  iq;
    logic [DW-1:0]    data;
  } acc_rec_t;

  function automatic logic is_cpu(input logic [SRC_W-1:0] s);
    return (s == SRC_CPU_PRG) || (s == SRC_CPU_DAT);
  endfunction
endpackage

// File: rtl/evb_phase.sv
module evb_phase (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic eclk
);
  logic ph_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_low <= 1'b1;
      eclk   <= 1'b0;
    end else begin
      ph_low <= ~ph_low;
      eclk   <= ph_low;
    end
  end

  assign tick = ph_low;
endmodule

// File: rtl/evb_track.sv
module evb_track
  import evb_pkg::*;
#(
  parameter int STR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             req_v,
  input  acc_rec_t         req_rec,
  input  logic [STR_W-1:0] req_str,
  output logic             cur_v,
  output logic             cur_first,
  output acc_rec_t         cur_rec,
  output logic [SRC_W-1:0] cur_acc,
  output logic             nxt_v,
  output logic [AW-1:0]    nxt_addr
);
  logic [STR_W-1:0] cur_rem, nxt_rem;
  logic             cont, take, nxt_first;
  acc_rec_t         nxt_rec;
  logic [SRC_W-1:0] nxt_acc;

  always_comb begin
    cont      = cur_v && (cur_rem != '0);
    take      = !cont && req_v;
    nxt_v     = cont || take;
    nxt_first = take;
    nxt_rec   = take ? req_rec : cur_rec;
    if (take)      nxt_rem = req_str;
    else if (cont) nxt_rem = cur_rem - 1'b1;
    else           nxt_rem = '0;
    if (take)      nxt_acc = req_rec.src;
    else if (cont) nxt_acc = SRC_NONE;
    else           nxt_acc = SRC_IDLE;
    nxt_addr  = nxt_v ? nxt_rec.addr : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_v     <= 1'b0;
      cur_first <= 1'b0;
      cur_rec   <= '0;
      cur_rem   <= '0;
      cur_acc   <= SRC_IDLE;
    end else if (tick) begin
      cur_v     <= nxt_v;
      cur_first <= nxt_first;
      cur_rec   <= nxt_rec;
      cur_rem   <= nxt_rem;
      cur_acc   <= nxt_acc;
    end
  end
endmodule

// File: rtl/evb_lane.sv
module evb_lane
  import evb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            cur_v,
  input  logic            cur_first,
  input  acc_rec_t        cur_rec,
  output logic [IQ_W-1:0] lo_iq,
  output logic [DW-1:0]   lo_ivd
);
  localparam int NLANE = DW / 8;

  logic          show, data_ok, odd;
  logic [DW-1:0] swz;

  assign show    = cur_v && cur_first;
  assign data_ok = show && cur_rec.rd && is_cpu(cur_rec.src);
  assign odd     = cur_rec.addr[0];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam bit HI = (g == NLANE - 1);
    always_comb begin
      if (cur_rec.word) begin
        if (odd) swz[g*8 +: 8] = HI ? cur_rec.data[7:0] : cur_rec.data[15:8];
        else     swz[g*8 +: 8] = cur_rec.data[g*8 +: 8];
      end else begin
        if (HI) swz[g*8 +: 8] = odd ? cur_rec.addr[15:8] : cur_rec.data[7:0];
        else    swz[g*8 +: 8] = odd ? cur_rec.data[7:0]  : cur_rec.addr[7:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_iq  <= '0;
      lo_ivd <= '0;
    end else if (tick) begin
      lo_iq  <= show ? cur_rec.iq : '0;
      lo_ivd <= data_ok ? swz : '0;
    end
  end
endmodule

// File: rtl/evb_pad.sv
module evb_pad
  import evb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             nxt_v,
  input  logic [AW-1:0]    nxt_addr,
  input  logic [SRC_W-1:0] cur_acc,
  input  logic [IQ_W-1:0]  lo_iq,
  input  logic [DW-1:0]    lo_ivd,
  output logic [AW-1:0]    pad_ad,
  output logic [SRC_W-1:0] pad_acc,
  output logic [IQ_W-1:0]  pad_iq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_ad  <= '0;
      pad_acc <= '0;
      pad_iq  <= '0;
    end else if (tick) begin
      pad_ad  <= nxt_v ? nxt_addr : '0;
      pad_acc <= '0;
      pad_iq  <= '0;
    end else begin
      pad_ad  <= lo_ivd;
      pad_acc <= cur_acc;
      pad_iq  <= lo_iq;
    end
  end
endmodule

// File: rtl/evb_mux.sv
module evb_mux
  import evb_pkg::*;
#(
  parameter int STR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_v,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_word,
  input  logic             req_rd,
  input  logic [SRC_W-1:0] req_src,
  input  logic [IQ_W-1:0]  req_iq,
  input  logic [STR_W-1:0] req_str,
  input  logic [DW-1:0]    req_data,
  output logic             eclk,
  output logic [AW-1:0]    pad_ad,
  output logic [SRC_W-1:0] pad_acc,
  output logic [IQ_W-1:0]  pad_iq
);
  logic             tick, cur_v, cur_first, nxt_v;
  acc_rec_t         req_rec, cur_rec;
  logic [SRC_W-1:0] cur_acc;
  logic [AW-1:0]    nxt_addr;
  logic [IQ_W-1:0]  lo_iq;
  logic [DW-1:0]    lo_ivd;

  assign req_rec = '{addr: req_addr, word: req_word, rd: req_rd,
                     src: req_src, iq: req_iq, data: req_data};

  evb_phase u_phase (.clk(clk), .rst(rst), .tick(tick), .eclk(eclk));

  evb_track #(.STR_W(STR_W)) u_track (
    .clk(clk), .rst(rst), .tick(tick), .req_v(req_v), .req_rec(req_rec),
    .req_str(req_str), .cur_v(cur_v), .cur_first(cur_first),
    .cur_rec(cur_rec), .cur_acc(cur_acc), .nxt_v(nxt_v), .nxt_addr(nxt_addr));

  evb_lane u_lane (
    .clk(clk), .rst(rst), .tick(tick), .cur_v(cur_v),
    .cur_first(cur_first), .cur_rec(cur_rec), .lo_iq(lo_iq), .lo_ivd(lo_ivd));

  evb_pad u_pad (
    .clk(clk), .rst(rst), .tick(tick), .nxt_v(nxt_v), .nxt_addr(nxt_addr),
    .cur_acc(cur_acc), .lo_iq(lo_iq), .lo_ivd(lo_ivd),
    .pad_ad(pad_ad), .pad_acc(pad_acc), .pad_iq(pad_iq));
endmodule

// File: rtl/evb_chk.sv
module evb_chk
  import evb_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             eclk,
  input logic [AW-1:0]    pad_ad,
  input logic [SRC_W-1:0] pad_acc,
  input logic [IQ_W-1:0]  pad_iq
);
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 3'd7) age <= age + 1'b1;
  end

  // R1: phases alternate every system clock
  a_r1_eclk_alternates: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd2) |-> (eclk != $past(eclk)));

  // R1: no low-phase fields in a high phase
  a_r1_high_quiet: assert property (@(posedge clk) disable iff (rst)
    eclk |-> (pad_acc == '0 && pad_iq == '0));

  // R4: a continuation cycle keeps the previous cycle's address
  a_r4_cont_same_addr: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd5 && !eclk && pad_acc == SRC_NONE) |-> ($past(pad_ad, 1) == $past(pad_ad, 3)));

  // R5: the cycle after a continuation cycle shows a null queue status
  a_r5_null_after_cont: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd5 && !eclk && pad_acc == SRC_NONE) |-> ##2 (pad_iq == '0));

  // R2: an idle cycle shows a zero address
  a_r2_idle_addr_zero: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd3 && !eclk && pad_acc == SRC_IDLE) |-> ($past(pad_ad) == '0));

  // R9: the cycle after an idle one has no queue status and no data
  a_r9_after_idle_empty: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd3 && !eclk && pad_acc == SRC_IDLE) |-> ##2 (pad_iq == '0 && pad_ad == '0));
endmodule

bind evb_mux evb_chk u_chk (
  .clk(clk), .rst(rst), .eclk(eclk), .pad_ad(pad_ad),
  .pad_acc(pad_acc), .pad_iq(pad_iq));

// File: tb/evb_mux_tb.sv
module evb_mux_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_v = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_word = 1'b0;
  logic        req_rd = 1'b0;
  logic [2:0]  req_src = 3'b001;
  logic [3:0]  req_iq = '0;
  logic [3:0]  req_str = '0;
  logic [15:0] req_data = '0;
  logic        eclk;
  logic [15:0] pad_ad;
  logic [2:0]  pad_acc;
  logic [3:0]  pad_iq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  evb_mux dut_i (
    .clk(clk), .rst(rst), .req_v(req_v), .req_addr(req_addr),
    .req_word(req_word), .req_rd(req_rd), .req_src(req_src), .req_iq(req_iq),
    .req_str(req_str), .req_data(req_data), .eclk(eclk), .pad_ad(pad_ad),
    .pad_acc(pad_acc), .pad_iq(pad_iq));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: optional request, then both phases compared.
  task automatic bus_cycle(input logic v, input logic [15:0] a, input logic w,
                           input logic rd, input logic [2:0] s, input logic [3:0] q,
                           input logic [3:0] st, input logic [15:0] d,
                           input logic [15:0] ea, input logic [2:0] eacc,
                           input logic [3:0] eiq, input logic [15:0] eivd,
                           input string tag);
    req_v = v; req_addr = a; req_word = w; req_rd = rd; req_src = s;
    req_iq = q; req_str = st; req_data = d;
    @(posedge clk); @(negedge clk);
    req_v = 1'b0;
    chk({tag, " R1 eclk high"}, {15'd0, eclk}, 16'd1);
    chk({tag, " R2 addr"}, pad_ad, ea);
    chk({tag, " R1 quiet high"}, {9'd0, pad_acc, pad_iq}, 16'd0);
    @(posedge clk); @(negedge clk);
    chk({tag, " R1 eclk low"}, {15'd0, eclk}, 16'd0);
    chk({tag, " R4 acc"}, {13'd0, pad_acc}, {13'd0, eacc});
    chk({tag, " R5 iq"}, {12'd0, pad_iq}, {12'd0, eiq});
    chk({tag, " ivd"}, pad_ad, eivd);
  endtask

  task automatic idle(input logic [3:0] eiq, input logic [15:0] eivd, input string tag);
    bus_cycle(1'b0, 16'h0, 1'b0, 1'b0, 3'b001, 4'h0, 4'h0, 16'h0,
              16'h0, 3'b100, eiq, eivd, tag);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R12 eclk", {15'd0, eclk}, 16'd0);
    chk("R12 pad_ad", pad_ad, 16'd0);
    chk("R12 acc/iq", {9'd0, pad_acc, pad_iq}, 16'd0);
    rst = 1'b0;
  endtask

  task automatic t_word_even;  // R6
    bus_cycle(1'b1, 16'h1234, 1'b1, 1'b1, 3'b001, 4'h5, 4'h0, 16'hA1B2,
              16'h1234, 3'b001, 4'h0, 16'h0, "R6 c0");
    idle(4'h5, 16'hA1B2, "R6 c1");
    idle(4'h0, 16'h0, "R6 c2");
  endtask

  task automatic t_word_odd;  // R7
    bus_cycle(1'b1, 16'h2001, 1'b1, 1'b1, 3'b010, 4'h6, 4'h0, 16'hC3D4,
              16'h2001, 3'b010, 4'h0, 16'h0, "R7 c0");
    idle(4'h6, 16'hD4C3, "R7 c1");
  endtask

  task automatic t_bytes;  // R8
    bus_cycle(1'b1, 16'h3040, 1'b0, 1'b1, 3'b001, 4'h8, 4'h0, 16'h005A,
              16'h3040, 3'b001, 4'h0, 16'h0, "R8 even c0");
    bus_cycle(1'b1, 16'h4071, 1'b0, 1'b1, 3'b010, 4'hA, 4'h0, 16'h007E,
              16'h4071, 3'b010, 4'h8, 16'h5A40, "R8 odd c0 / even c1");
    idle(4'hA, 16'h407E, "R8 odd c1");
  endtask

  task automatic t_no_data;  // R9
    bus_cycle(1'b1, 16'h5000, 1'b1, 1'b0, 3'b001, 4'h7, 4'h0, 16'hFFFF,
              16'h5000, 3'b001, 4'h0, 16'h0, "R9 write c0");
    bus_cycle(1'b1, 16'h6002, 1'b1, 1'b1, 3'b011, 4'h3, 4'h0, 16'h1111,
              16'h6002, 3'b011, 4'h7, 16'h0, "R9 non-cpu c0 / write c1");
    idle(4'h3, 16'h0, "R9 non-cpu c1");
  endtask

  task automatic t_stretch;  // R3 R5 R11
    bus_cycle(1'b1, 16'h7000, 1'b1, 1'b1, 3'b001, 4'h9, 4'h2, 16'hBEEF,
              16'h7000, 3'b001, 4'h0, 16'h0, "R3 c0");
    bus_cycle(1'b1, 16'h9999, 1'b1, 1'b1, 3'b010, 4'hF, 4'h0, 16'h5555,
              16'h7000, 3'b000, 4'h9, 16'hBEEF, "R11 dropped c1");
    bus_cycle(1'b0, 16'h0, 1'b0, 1'b0, 3'b001, 4'h0, 4'h0, 16'h0,
              16'h7000, 3'b000, 4'h0, 16'h0, "R5 c2");
    idle(4'h0, 16'h0, "R5 c3 null");
    idle(4'h0, 16'h0, "R11 c4");
  endtask

  task automatic t_back2back;  // R10
    bus_cycle(1'b1, 16'h0100, 1'b1, 1'b1, 3'b001, 4'h1, 4'h1, 16'h1122,
              16'h0100, 3'b001, 4'h0, 16'h0, "R10 A c0");
    bus_cycle(1'b0, 16'h0, 1'b0, 1'b0, 3'b001, 4'h0, 4'h0, 16'h0,
              16'h0100, 3'b000, 4'h1, 16'h1122, "R10 A c1");
    bus_cycle(1'b1, 16'h0202, 1'b1, 1'b0, 3'b010, 4'h2, 4'h0, 16'h0,
              16'h0202, 3'b010, 4'h0, 16'h0, "R10 B c0 / A null");
    bus_cycle(1'b1, 16'h0304, 1'b1, 1'b1, 3'b101, 4'h4, 4'h0, 16'hABCD,
              16'h0304, 3'b101, 4'h2, 16'h0, "R10 C c0 / B c1");
    idle(4'h4, 16'h0, "R10 C c1");
    idle(4'h0, 16'h0, "R10 tail");
  endtask

  initial begin
    t_reset();
    t_word_even();
    t_word_odd();
    t_bytes();
    t_no_data();
    t_stretch();
    t_back2back();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule